// File: doc/BRIEF.md
# Dual-Channel Set/Reset PWM Generator

This block runs one up-counter and drives two pulse outputs from it. Every output has its own pair of compare values. A match on the first value of the pair moves the output to its active level. A match on the second value returns the output to its idle level. Channel A's return value also ends the counter period. A per-channel polarity bit chooses which level is active, and the idle level follows from it. This gives independent control of where each pulse starts and ends within the period, which a single duty-cycle compare cannot do.

Software drives the block through a simple register write port. That port loads the four compare values, a control byte that holds the two polarity bits, and a run bit. A combinational read port returns every register and the live count. The control byte can only be changed while the counter is stopped. Writing it forces both outputs to their idle levels at once, which sets up a known starting state before a run.

Top module: `pwm2ch_setclr`

## Requirements
- R1: After reset the count is 0, the run bit is 0, the control byte reads 0x00, all compare values read 0, and both outputs are low.
- R2: While the run bit is 1, the count rises by one each clock. In the clock after the count equals the channel A clear value (address 1), it becomes 0 instead, so the period is that value plus one.
- R3: With polarity 0 (control bit 0 for A, bit 1 for B), an output goes high one clock after the count equals its set value and goes low one clock after the count equals its clear value.
- R4: With polarity 1, the levels invert: the output goes low after a set match and high after a clear match.
- R5: Channel B uses its set value (address 2) and clear value (address 3) and its own polarity bit (control bit 1), independent of channel A. Channel A uses set address 0 and clear address 1.
- R6: When the set value and the clear value of a channel match on the same count, the clear match wins.
- R7: A control byte write (address 4) while stopped sets output A to written bit 0 and output B to written bit 1 on the next clock.
- R8: A control byte write while the run bit is 1 is ignored: the byte keeps its old value and the outputs are not disturbed.
- R9: Control bits 7..2 have no effect on the outputs and read back as written.
- R10: While the run bit is 0 (address 5, data bit 0), the count and both outputs hold their values.
- R11: A compare value write takes effect from the next clock, also while running. Read address 6 returns the count, and addresses 7 and above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0..5) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address (0..6) |
| rd_data | output | 16 | Combinational read data |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
The assertions assume that reset is held low through the first clock edge. They also assume that the polarity bits change only through a control write, which the block itself blocks while running, so the level after a match can be compared with the polarity of the cycle before. The stimulus therefore issues one write per cycle and no more. It stops the counter before each intended control change, and it deliberately includes one control write while running to exercise the guard. Compare values are changed both while stopped and mid-run, including a clear value below the current count, so the counter must wrap through the top of its range.

// File: rtl/pwm2ch_pkg.sv
// Package: shared widths and register addresses of the two-channel set/clear PWM.
// Assumes a single write port that carries one register per cycle.
package pwm2ch_pkg;
    localparam int CNT_W  = 16;
    localparam int CTRL_W = 8;
    localparam int ADDR_W = 3;
    localparam int N_CH   = 2;

    localparam logic [ADDR_W-1:0] SEL_SET_A = 3'd0;
    localparam logic [ADDR_W-1:0] SEL_CLR_A = 3'd1;
    localparam logic [ADDR_W-1:0] SEL_SET_B = 3'd2;
    localparam logic [ADDR_W-1:0] SEL_CLR_B = 3'd3;
    localparam logic [ADDR_W-1:0] SEL_CTRL  = 3'd4;
    localparam logic [ADDR_W-1:0] SEL_RUN   = 3'd5;
    localparam logic [ADDR_W-1:0] SEL_COUNT = 3'd6;
endpackage

// File: rtl/pwm2ch_counter.sv
// Module: period counter. It counts up while run is high and returns to zero
// in the clock after it equals the limit. Assumes limit comes from a register.
module pwm2ch_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt
);
    logic wrap;

    // Detect the end of the period.
    always_comb wrap = (cnt == limit);

    // Advance, wrap or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (run)      cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !wrap |=> cnt == W'($past(cnt) + 1'b1));
    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && wrap |=> cnt == '0);
    // R10
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));
endmodule

// File: rtl/pwm2ch_regs.sv
// Module: register file. It holds the compare values, the control byte and the
// run bit, and supplies the read mux. Control writes are taken only while
// stopped, and an accepted one raises load so the channels pick up their idle levels.
module pwm2ch_regs
    import pwm2ch_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int CW = CTRL_W,
    parameter int AW = ADDR_W,
    parameter int NC = N_CH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic [AW-1:0]        rd_addr,
    input  logic [W-1:0]         cnt,
    output logic [W-1:0]         rd_data,
    output logic                 run,
    output logic [NC-1:0][W-1:0] set_val,
    output logic [NC-1:0][W-1:0] clr_val,
    output logic [NC-1:0]        pol,
    output logic                 load,
    output logic [NC-1:0]        load_lvl
);
    logic [CW-1:0] ctrl_q;
    logic          ctrl_wr;

    // A control write counts only when the counter is stopped.
    always_comb ctrl_wr = wr_en && (wr_addr == SEL_CTRL) && !run;
    always_comb load = ctrl_wr;
    always_comb load_lvl = wr_data[NC-1:0];
    always_comb pol = ctrl_q[NC-1:0];

    // Store the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wr_data[CW-1:0];
    end

    // Store the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                             run <= 1'b0;
        else if (wr_en && wr_addr == SEL_RUN)   run <= wr_data[0];
    end

    // Store the compare values: address 2*ch is set, 2*ch+1 is clear.
    for (genvar ch = 0; ch < NC; ch++) begin : g_cmp
        localparam logic [AW-1:0] SET_ADR = AW'(2 * ch);
        localparam logic [AW-1:0] CLR_ADR = AW'(2 * ch + 1);
        // Load this channel's set value.
        always_ff @(posedge clk) begin
            if (!rst_n)                          set_val[ch] <= '0;
            else if (wr_en && wr_addr == SET_ADR) set_val[ch] <= wr_data;
        end
        // Load this channel's clear value.
        always_ff @(posedge clk) begin
            if (!rst_n)                          clr_val[ch] <= '0;
            else if (wr_en && wr_addr == CLR_ADR) clr_val[ch] <= wr_data;
        end
    end

    // Read mux.
    always_comb begin
        case (rd_addr)
            SEL_SET_A: rd_data = set_val[0];
            SEL_CLR_A: rd_data = clr_val[0];
            SEL_SET_B: rd_data = set_val[1];
            SEL_CLR_B: rd_data = clr_val[1];
            SEL_CTRL:  rd_data = W'(ctrl_q);
            SEL_RUN:   rd_data = W'(run);
            SEL_COUNT: rd_data = cnt;
            default:   rd_data = '0;
        endcase
    end

    // R8
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == SEL_CTRL && run |=> $stable(ctrl_q));
endmodule

// File: rtl/pwm2ch_channel.sv
// Module: one output channel. A clear match drives the idle level (= pol) and
// a set match drives the active level (= !pol). Clear wins a tie. load
// (only while stopped) forces load_lvl. The output holds while stopped.
module pwm2ch_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] set_val,
    input  logic [W-1:0] clr_val,
    input  logic         pol,
    input  logic         load,
    input  logic         load_lvl,
    output logic         out
);
    logic hit_set, hit_clr;

    // Compare the live count with both edges.
    always_comb begin
        hit_set = (cnt == set_val);
        hit_clr = (cnt == clr_val);
    end

    // Registered output level.
    always_ff @(posedge clk) begin
        if (!rst_n)               out <= 1'b0;
        else if (load)            out <= load_lvl;
        else if (run && hit_clr)  out <= pol;
        else if (run && hit_set)  out <= !pol;
    end

    // R3 R4 R6
    clr_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && hit_clr |=> out == $past(pol));
    // R3 R4
    set_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && hit_set && !hit_clr |=> out == !$past(pol));
    // R7
    load_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out == $past(load_lvl));
    // R10
    frozen_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load |=> $stable(out));
endmodule

// File: rtl/pwm2ch_setclr.sv
// Module: top level of the two-channel set/clear PWM. It ties the register
// file, the shared counter and one channel per output together. Channel A's
// clear value sets the period.
module pwm2ch_setclr
    import pwm2ch_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic          pwm_a,
    output logic          pwm_b
);
    localparam int NC = N_CH;

    logic                 run, load;
    logic [W-1:0]         cnt;
    logic [NC-1:0][W-1:0] set_val, clr_val;
    logic [NC-1:0]        pol, load_lvl, outs;

    pwm2ch_regs #(.W(W), .CW(CTRL_W), .AW(AW), .NC(NC)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt), .rd_data(rd_data),
        .run(run), .set_val(set_val), .clr_val(clr_val), .pol(pol),
        .load(load), .load_lvl(load_lvl)
    );

    pwm2ch_counter #(.W(W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run(run), .limit(clr_val[0]), .cnt(cnt)
    );

    for (genvar ch = 0; ch < NC; ch++) begin : g_ch
        pwm2ch_channel #(.W(W)) ch_i (
            .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
            .set_val(set_val[ch]), .clr_val(clr_val[ch]), .pol(pol[ch]),
            .load(load), .load_lvl(load_lvl[ch]), .out(outs[ch])
        );
    end

    // Map the channel vector onto the named pins.
    always_comb begin
        pwm_a = outs[0];
        pwm_b = outs[1];
    end
endmodule

// File: tb/pwm2ch_setclr_tb.sv
// Bench: a behavioural reference model, checked every clock and by directed checks.
module pwm2ch_setclr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd6;
    logic [15:0] rd_data;
    logic        pwm_a, pwm_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference state
    int m_cnt, m_set_a, m_clr_a, m_set_b, m_clr_b, m_ctrl, m_run, m_a, m_b;

    pwm2ch_setclr dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_read(int a);
        case (a)
            0: return m_set_a;
            1: return m_clr_a;
            2: return m_set_b;
            3: return m_clr_b;
            4: return m_ctrl;
            5: return m_run;
            6: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // Reference model, updated at each rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        int oc, oa0, ob0;
        oc = m_cnt; oa0 = m_clr_a; ob0 = m_clr_b;
        if (!rst_n) begin
            m_cnt = 0; m_set_a = 0; m_clr_a = 0; m_set_b = 0; m_clr_b = 0;
            m_ctrl = 0; m_run = 0; m_a = 0; m_b = 0;
        end else begin
            if (m_run == 1) begin
                if (oc == oa0)            m_a = m_ctrl & 1;
                else if (oc == m_set_a)   m_a = 1 - (m_ctrl & 1);
                if (oc == ob0)            m_b = (m_ctrl >> 1) & 1;
                else if (oc == m_set_b)   m_b = 1 - ((m_ctrl >> 1) & 1);
                m_cnt = (oc == oa0) ? 0 : (oc + 1) % 65536;
            end
            if (wr_en) begin
                case (int'(wr_addr))
                    0: m_set_a = int'(wr_data);
                    1: m_clr_a = int'(wr_data);
                    2: m_set_b = int'(wr_data);
                    3: m_clr_b = int'(wr_data);
                    4: if (m_run == 0) begin
                           m_ctrl = int'(wr_data[7:0]);
                           m_a = int'(wr_data[0]);
                           m_b = int'(wr_data[1]);
                       end
                    5: m_run = int'(wr_data[0]);
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison, a quarter period after the edge.
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (!done) begin
            chk("R3 R4 R5 R6 R10 pwm_a", int'(pwm_a), m_a);
            chk("R3 R4 R5 R6 R10 pwm_b", int'(pwm_b), m_b);
            chk("R2 R11 rd_data", int'(rd_data), m_read(int'(rd_addr)));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(int a, int exp, string req);
        @(negedge clk);
        rd_addr = 3'(a);
        #1;
        chk(req, int'(rd_data), exp);
        rd_addr = 3'd6;
    endtask

    initial begin
        int c0;
        int bad_b;
        idle(3);
        rst_n = 1'b1;
        // R1 reset values
        chk("R1 pwm_a", int'(pwm_a), 0);
        chk("R1 pwm_b", int'(pwm_b), 0);
        rd_chk(4, 0, "R1 ctrl");
        rd_chk(5, 0, "R1 run");
        rd_chk(6, 0, "R1 count");
        rd_chk(1, 0, "R1 clear A");
        rd_chk(7, 0, "R11 unused address");

        // R3 R5 polarity 0, distinct windows
        wr(0, 3); wr(1, 9); wr(2, 5); wr(3, 7);
        wr(5, 1);
        idle(35);
        wr(5, 0);
        // R10 freeze
        @(negedge clk); rd_addr = 3'd6; #1; c0 = int'(rd_data);
        idle(6);
        rd_chk(6, c0, "R10 count held");

        // R7 initial levels on control write while stopped
        wr(4, 3);
        chk("R7 pwm_a init", int'(pwm_a), 1);
        chk("R7 pwm_b init", int'(pwm_b), 1);
        // R4 inverted polarity
        wr(5, 1);
        idle(30);
        // R8 control write while running is ignored
        wr(4, 0);
        rd_chk(4, 3, "R8 ctrl unchanged");
        idle(12);
        // R11 shorten period mid-run, below the current count
        wr(1, 4);
        idle(70);
        wr(1, 6);
        idle(20);
        wr(5, 0);

        // R9 upper control bits stored, no effect on levels
        wr(4, 'hFC);
        rd_chk(4, 'hFC, "R9 readback");
        chk("R9 pwm_a", int'(pwm_a), 0);
        chk("R9 pwm_b", int'(pwm_b), 0);

        // R6 equal set and clear on channel B
        wr(2, 4); wr(3, 4);
        wr(5, 1);
        bad_b = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_b != 1'b0) bad_b++;
        end
        chk("R6 clear wins", bad_b, 0);
        wr(5, 0);
        idle(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule